// File: doc/BRIEF.md
# Block Cipher Control Shell with Word FIFOs

This block is the control shell that sits around a block-cipher datapath. Software writes a control word that holds the unit enable, the cipher direction, an algorithm and chaining selector, a key-length selector, a data-swap selector, a one-shot queue-clear strobe and two DMA enables. Input words go into a data-in port and are buffered in an input FIFO. Result words are buffered in an output FIFO and leave through a show-ahead data-out port. Status outputs report whether the input FIFO has room, whether a result is waiting, and whether the core is busy.

The cipher arithmetic is replaced by a placeholder core with a fixed latency. It takes four input words and produces four result words, mixing each word with the key and IV registers. A special selector code starts a key-preparation pass instead of data processing. When that pass ends, the unit drops busy and clears its own enable, so software can poll until both read 0. Two DMA request lines, each with a burst hint, move words in and out. The output side always wins when both lines would be active at once.

Top module: `cipher_shell`

## Requirements
- R1: After reset the control word reads 0, busy is 0, the input-room flag is 1 and the result-waiting flag is 0.
- R2: With enable 1 and a selector other than 3'b111, each group of four stored input words s0..s3 produces four results in order. Result i is s_i XOR key[i] XOR iv[i] XOR a direction mask, passed through the output swap.
- R3: The direction bit (control bit 1) set to 1 selects decryption, and the direction mask is then all ones. Set to 0 it selects encryption, and the mask is all zeros.
- R4: The swap field (control bits 8:7) acts on words entering and leaving: 00 passes the word unchanged, 01 exchanges the two 16-bit halves, 10 reverses the byte order and 11 reverses the bit order.
- R5: Writing enable 1 (bit 0) with selector 3'b111 (bits 4:2) raises busy for a key-preparation pass that yields no result words. At its end busy and enable both return to 0 on the same clock edge.
- R6: A control write with the clear strobe (bit 9) empties both FIFOs when enable is 0 at the time of the write. When enable is 1 the strobe is ignored and stored words remain.
- R7: The input-room flag is 1 while fewer than 8 words are stored. A data-in write while 8 words are stored is discarded.
- R8: The result-waiting flag is 1 exactly while at least one result word can be read, and each read strobe removes one word.
- R9: The core starts a block only when at least four input words are stored and the output FIFO has four free places. Busy stays high from that start until the last result is stored.
- R10: The input request is raised only when the input DMA enable (bit 10) and the unit enable are 1 and there is input room. The output request is raised when the output DMA enable (bit 11) is 1 and a result is waiting. Each burst hint is 1 only when four free places, or four stored results, exist.
- R11: The input request is held low in any cycle in which the output request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 12 | Control word write data |
| ctl_q | output | 12 | Control word readback (clear strobe reads 0) |
| key_we | input | 1 | Key word write strobe |
| key_idx | input | 2 | Key word index |
| key_wdata | input | 32 | Key word data |
| iv_we | input | 1 | IV word write strobe |
| iv_idx | input | 2 | IV word index |
| iv_wdata | input | 32 | IV word data |
| din_we | input | 1 | Data-in write strobe |
| din_data | input | 32 | Data-in word |
| dout_re | input | 1 | Data-out read strobe |
| dout_data | output | 32 | Oldest result word, after swap |
| busy | output | 1 | Core is running a block or a key pass |
| in_nf | output | 1 | Input FIFO can take a word |
| out_ne | output | 1 | Output FIFO holds a word |
| dma_in_req | output | 1 | Input DMA request |
| dma_in_burst | output | 1 | Input request may be served as a 4-word burst |
| dma_out_req | output | 1 | Output DMA request |
| dma_out_burst | output | 1 | Output request may be served as a 4-word burst |

## Verification
The hardest case to reach is a full input queue with a discarded ninth word. With the unit disabled, no block drains the queue, so the overflow write is easy to make. The harder part is proving from the ports that the word was dropped. The bench fills eight words while disabled and then enables the unit. It expects exactly two blocks of results, then sends one more block. If the dropped word had been stored, every later result would be shifted and would miscompare.

// File: rtl/cshell_pkg.sv
package cshell_pkg;
   localparam int unsigned CTL_W    = 12;
   localparam int unsigned B_EN     = 0;
   localparam int unsigned B_DIR    = 1;
   localparam int unsigned B_ALG_LO = 2;
   localparam int unsigned B_KL_LO  = 5;
   localparam int unsigned B_SW_LO  = 7;
   localparam int unsigned B_CLR    = 9;
   localparam int unsigned B_DMAI   = 10;
   localparam int unsigned B_DMAO   = 11;
   localparam logic [2:0]  KEY_ALG  = 3'b111;

   typedef enum logic [1:0] {
      SWP_NONE = 2'b00,
      SWP_HALF = 2'b01,
      SWP_BYTE = 2'b10,
      SWP_BIT  = 2'b11
   } swap_e;

   typedef enum logic [2:0] {
      C_IDLE, C_LOAD, C_RUN, C_PUT, C_KEY
   } core_st_e;
endpackage

// File: rtl/cshell_fifo.sv
module cshell_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic [CNT_W-1:0] count
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cshell_fifo: DEPTH must be a power of two of at least 2");
   end

   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign do_push = push && (count != FULL_C);
   assign do_pop  = pop && (count != '0);
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end
endmodule

// File: rtl/cshell_swap.sv
module cshell_swap
   import cshell_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] din,
   input  swap_e        mode,
   output logic [W-1:0] dout
);
   if (W % 16 != 0) begin : g_bad_w
      $error("cshell_swap: W must be a multiple of 16");
   end

   localparam int unsigned NBYTE = W / 8;

   logic [W-1:0] half_x, byte_x, bit_x;

   assign half_x = {din[W/2-1:0], din[W-1:W/2]};

   for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      assign byte_x[8*b +: 8] = din[8*(NBYTE-1-b) +: 8];
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bit_x[i] = din[W-1-i];
   end

   always_comb begin
      case (mode)
         SWP_HALF: dout = half_x;
         SWP_BYTE: dout = byte_x;
         SWP_BIT:  dout = bit_x;
         default:  dout = din;
      endcase
   end
endmodule

// File: rtl/cshell_core.sv
module cshell_core
   import cshell_pkg::*;
#(
   parameter int unsigned W     = 32,
   parameter int unsigned BLK   = 4,
   parameter int unsigned LAT   = 6,
   parameter int unsigned CNT_W = 4,
   localparam int unsigned IDX_W = $clog2(BLK),
   localparam int unsigned LAT_W = $clog2(LAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [2:0]       alg,
   input  logic             dir,
   input  logic [W-1:0]     key_i [BLK],
   input  logic [W-1:0]     iv_i  [BLK],
   input  logic [CNT_W-1:0] in_cnt,
   input  logic [CNT_W-1:0] out_free,
   input  logic [W-1:0]     in_rdata,
   output logic             in_pop,
   output logic             out_push,
   output logic [W-1:0]     out_wdata,
   output logic             busy,
   output logic             key_done
);
   if (BLK < 2 || (BLK & (BLK - 1)) != 0) begin : g_bad_blk
      $error("cshell_core: BLK must be a power of two of at least 2");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("cshell_core: LAT must be at least 1");
   end

   localparam logic [CNT_W-1:0] BLK_C  = CNT_W'(BLK);
   localparam logic [IDX_W-1:0] LAST_I = IDX_W'(BLK - 1);
   localparam logic [LAT_W-1:0] LAST_L = LAT_W'(LAT - 1);

   core_st_e         st;
   logic [IDX_W-1:0] idx;
   logic [LAT_W-1:0] lat;
   logic [W-1:0]     hold [BLK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= C_IDLE;
         idx <= '0;
         lat <= '0;
      end else begin
         case (st)
            C_IDLE: begin
               idx <= '0;
               lat <= '0;
               if (en) begin
                  if (alg == KEY_ALG) st <= C_KEY;
                  else if (in_cnt >= BLK_C && out_free >= BLK_C) st <= C_LOAD;
               end
            end
            C_LOAD: begin
               if (idx == LAST_I) begin
                  idx <= '0;
                  st  <= C_RUN;
               end else idx <= idx + 1'b1;
            end
            C_RUN: begin
               if (lat == LAST_L) begin
                  lat <= '0;
                  st  <= C_PUT;
               end else lat <= lat + 1'b1;
            end
            C_PUT: begin
               if (idx == LAST_I) begin
                  idx <= '0;
                  st  <= C_IDLE;
               end else idx <= idx + 1'b1;
            end
            C_KEY: begin
               if (lat == LAST_L) begin
                  lat <= '0;
                  st  <= C_IDLE;
               end else lat <= lat + 1'b1;
            end
            default: st <= C_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (st == C_LOAD) hold[idx] <= in_rdata;
   end

   assign in_pop    = (st == C_LOAD);
   assign out_push  = (st == C_PUT);
   assign out_wdata = hold[idx] ^ key_i[idx] ^ iv_i[idx] ^ {W{dir}};
   assign busy      = (st != C_IDLE);
   assign key_done  = (st == C_KEY) && (lat == LAST_L);
endmodule

// File: rtl/cshell_dma.sv
module cshell_dma #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned BURST = 4,
   parameter int unsigned CNT_W = 4
) (
   input  logic             unit_en,
   input  logic             in_en,
   input  logic             out_en,
   input  logic [CNT_W-1:0] in_count,
   input  logic [CNT_W-1:0] out_count,
   output logic             in_req,
   output logic             in_burst,
   output logic             out_req,
   output logic             out_burst
);
   if (BURST > DEPTH) begin : g_bad_burst
      $error("cshell_dma: BURST must not exceed DEPTH");
   end

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST);

   logic [CNT_W-1:0] in_free;
   logic             in_raw;

   assign in_free   = DEPTH_C - in_count;
   assign in_raw    = in_en && unit_en && (in_count != DEPTH_C);
   assign out_req   = out_en && (out_count != '0);
   assign in_req    = in_raw && !out_req;
   assign in_burst  = in_req && (in_free >= BURST_C);
   assign out_burst = out_req && (out_count >= BURST_C);
endmodule

// File: rtl/cipher_shell.sv
module cipher_shell
   import cshell_pkg::*;
#(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned BLK   = 4,
   parameter int unsigned LAT   = 6,
   localparam int unsigned IDX_W = $clog2(BLK),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_q,
   input  logic             key_we,
   input  logic [IDX_W-1:0] key_idx,
   input  logic [W-1:0]     key_wdata,
   input  logic             iv_we,
   input  logic [IDX_W-1:0] iv_idx,
   input  logic [W-1:0]     iv_wdata,
   input  logic             din_we,
   input  logic [W-1:0]     din_data,
   input  logic             dout_re,
   output logic [W-1:0]     dout_data,
   output logic             busy,
   output logic             in_nf,
   output logic             out_ne,
   output logic             dma_in_req,
   output logic             dma_in_burst,
   output logic             dma_out_req,
   output logic             dma_out_burst
);
   if (DEPTH < 2 * BLK) begin : g_bad_depth
      $error("cipher_shell: DEPTH must hold at least two blocks");
   end

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [W-1:0]     key_q [BLK];
   logic [W-1:0]     iv_q  [BLK];
   logic             key_done, clr;
   logic             in_pop, out_push;
   logic [W-1:0]     din_sw, in_rdata, out_wdata, out_rdata;
   logic [CNT_W-1:0] in_count, out_count, out_free;
   swap_e            swap_mode;

   assign swap_mode = swap_e'(ctl_q[B_SW_LO +: 2]);
   assign clr       = ctl_we && ctl_wdata[B_CLR] && !ctl_q[B_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         if (ctl_we) begin
            ctl_q        <= ctl_wdata;
            ctl_q[B_CLR] <= 1'b0;
         end
         if (key_done) ctl_q[B_EN] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < BLK; i++) begin
            key_q[i] <= '0;
            iv_q[i]  <= '0;
         end
      end else begin
         if (key_we) key_q[key_idx] <= key_wdata;
         if (iv_we)  iv_q[iv_idx]   <= iv_wdata;
      end
   end

   cshell_swap #(.W(W)) u_swp_in (
      .din  (din_data),
      .mode (swap_mode),
      .dout (din_sw)
   );

   cshell_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo_in (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (din_we),
      .wdata (din_sw),
      .pop   (in_pop),
      .rdata (in_rdata),
      .count (in_count)
   );

   cshell_core #(.W(W), .BLK(BLK), .LAT(LAT), .CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctl_q[B_EN]),
      .alg       (ctl_q[B_ALG_LO +: 3]),
      .dir       (ctl_q[B_DIR]),
      .key_i     (key_q),
      .iv_i      (iv_q),
      .in_cnt    (in_count),
      .out_free  (out_free),
      .in_rdata  (in_rdata),
      .in_pop    (in_pop),
      .out_push  (out_push),
      .out_wdata (out_wdata),
      .busy      (busy),
      .key_done  (key_done)
   );

   cshell_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo_out (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (out_push),
      .wdata (out_wdata),
      .pop   (dout_re),
      .rdata (out_rdata),
      .count (out_count)
   );

   cshell_swap #(.W(W)) u_swp_out (
      .din  (out_rdata),
      .mode (swap_mode),
      .dout (dout_data)
   );

   assign out_free = DEPTH_C - out_count;
   assign in_nf    = (in_count != DEPTH_C);
   assign out_ne   = (out_count != '0);

   cshell_dma #(.DEPTH(DEPTH), .BURST(BLK), .CNT_W(CNT_W)) u_dma (
      .unit_en   (ctl_q[B_EN]),
      .in_en     (ctl_q[B_DMAI]),
      .out_en    (ctl_q[B_DMAO]),
      .in_count  (in_count),
      .out_count (out_count),
      .in_req    (dma_in_req),
      .in_burst  (dma_in_burst),
      .out_req   (dma_out_req),
      .out_burst (dma_out_burst)
   );
endmodule

// File: rtl/cshell_chk.sv
module cshell_chk
   import cshell_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_we,
   input logic [CTL_W-1:0] ctl_wdata,
   input logic [CTL_W-1:0] ctl_q,
   input logic             busy,
   input logic             in_nf,
   input logic             out_ne,
   input logic             din_we,
   input logic             dma_in_req,
   input logic             dma_out_req
);
   p_keyprep_drops_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && ctl_q[B_ALG_LO +: 3] == KEY_ALG) |-> !ctl_q[B_EN]);

   p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[B_CLR] && !ctl_q[B_EN] && !busy) |=> (!out_ne && in_nf));

   p_room_lost_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_nf) |-> $past(din_we));

   p_result_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_ne) |-> $past(busy));

   p_in_req_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dma_in_req |-> (in_nf && ctl_q[B_DMAI] && ctl_q[B_EN]));

   p_out_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dma_out_req |-> !dma_in_req);
endmodule

bind cipher_shell cshell_chk u_chk (.*);

// File: tb/sim_cipher_shell.sv
module sim_cipher_shell;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [11:0] ctl_wdata = '0;
   logic [11:0] ctl_q;
   logic        key_we = 1'b0, iv_we = 1'b0;
   logic [1:0]  key_idx = '0, iv_idx = '0;
   logic [31:0] key_wdata = '0, iv_wdata = '0;
   logic        din_we = 1'b0;
   logic [31:0] din_data = '0;
   logic        dout_re = 1'b0;
   logic [31:0] dout_data;
   logic        busy, in_nf, out_ne;
   logic        dma_in_req, dma_in_burst, dma_out_req, dma_out_burst;

   always #2.5 clk = ~clk;

   cipher_shell u0 (.*);

   int          n_chk = 0, n_bad = 0;
   logic [31:0] kv [4];
   logic [31:0] ivv [4];
   logic [31:0] exp_q [$];
   logic [1:0]  cur_sw = 2'b00;
   logic        cur_dir = 1'b0;
   bit          mon_on = 1'b1, man_pop = 1'b0;
   int          n_seen = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] swp(input logic [31:0] w, input logic [1:0] m);
      logic [31:0] r;
      case (m)
         2'b01: r = {w[15:0], w[31:16]};
         2'b10: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
         2'b11: for (int i = 0; i < 32; i++) r[i] = w[31-i];
         default: r = w;
      endcase
      return r;
   endfunction

   task automatic wr_ctl(input logic en, input logic dir, input logic [2:0] alg,
                         input logic [1:0] sw, input logic clr, input logic di, input logic dout);
      @(negedge clk);
      ctl_we = 1'b1;
      ctl_wdata = {dout, di, clr, sw, 2'b10, alg, dir, en};
      @(negedge clk);
      ctl_we = 1'b0;
      cur_sw = sw;
      cur_dir = dir;
   endtask

   task automatic put_word(input logic [31:0] w);
      @(negedge clk);
      din_we = 1'b1;
      din_data = w;
      @(negedge clk);
      din_we = 1'b0;
   endtask

   // driver: one block of four words, expectations pushed to the scoreboard
   task automatic send_block(input logic [31:0] base);
      for (int i = 0; i < 4; i++) begin
         logic [31:0] w;
         w = base ^ (32'h0101_0101 * (i + 1));
         exp_q.push_back(swp(swp(w, cur_sw) ^ kv[i] ^ ivv[i] ^ {32{cur_dir}}, cur_sw));
         put_word(w);
      end
   endtask

   task automatic drain(input int lim);
      for (int c = 0; c < lim && exp_q.size() != 0; c++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor: pops and compares every result as it appears
   always @(negedge clk) begin
      dout_re = 1'b0;
      if (rst_n && out_ne && mon_on) begin
         if (exp_q.size() == 0) check("R8 unexpected word", dout_data, 32'h0);
         else check("R2/R3/R4 result", dout_data, exp_q.pop_front());
         n_seen++;
         dout_re = 1'b1;
      end else if (rst_n && out_ne && man_pop) begin
         man_pop = 1'b0;
         dout_re = 1'b1;
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit seen_busy;
      int wait_c;
      for (int i = 0; i < 4; i++) begin
         kv[i]  = 32'hA5C3_0000 + 32'h0001_1001 * i;
         ivv[i] = 32'h0F1E_2D3C ^ (32'h1111_0000 << i);
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 ctl", {20'h0, ctl_q}, 32'h0);
      check("R1 busy", {31'h0, busy}, 32'h0);
      check("R1 in_nf", {31'h0, in_nf}, 32'h1);
      check("R1 out_ne", {31'h0, out_ne}, 32'h0);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         key_we = 1'b1; key_idx = 2'(i); key_wdata = kv[i];
         iv_we = 1'b1; iv_idx = 2'(i); iv_wdata = ivv[i];
      end
      @(negedge clk);
      key_we = 1'b0; iv_we = 1'b0;

      // R5 key preparation pass
      wr_ctl(1, 1, 3'b111, 2'b00, 0, 0, 0);
      seen_busy = 0;
      wait_c = 0;
      while (wait_c < 100 && !(seen_busy && !busy)) begin
         @(negedge clk);
         if (busy) seen_busy = 1;
         wait_c++;
      end
      check("R5 busy seen", {31'h0, seen_busy}, 32'h1);
      check("R5 en cleared", {31'h0, ctl_q[0]}, 32'h0);
      check("R5 no words", {31'h0, out_ne}, 32'h0);

      // R2 R3 R4 data blocks, every swap mode and both directions
      for (int m = 0; m < 4; m++) begin
         for (int d = 0; d < 2; d++) begin
            wr_ctl(1, d[0], 3'b000, 2'(m), 0, 0, 0);
            send_block(32'h1234_5678 + 32'h0F00_00F1 * (m * 2 + d));
            drain(200);
            check("R2 scoreboard empty", exp_q.size(), 0);
         end
      end

      // R7 overflow with unit disabled, then R9 two blocks only
      wr_ctl(0, 0, 3'b000, 2'b00, 0, 0, 0);
      wr_ctl(0, 0, 3'b000, 2'b00, 1, 0, 0);
      n_seen = 0;
      send_block(32'h0000_1000);
      check("R9 no start while disabled", {31'h0, busy}, 32'h0);
      send_block(32'h0000_2000);
      check("R7 full flag", {31'h0, in_nf}, 32'h0);
      put_word(32'hDEAD_BEEF);
      wr_ctl(1, 0, 3'b000, 2'b00, 0, 0, 0);
      drain(300);
      check("R7 eight results", n_seen, 8);
      check("R7 room again", {31'h0, in_nf}, 32'h1);
      send_block(32'h0000_3000);
      drain(200);
      check("R7 stream aligned", exp_q.size(), 0);

      // R9 partial block does not start
      mon_on = 0;
      for (int i = 0; i < 3; i++) put_word(32'h7000_0000 + i);
      repeat (10) @(negedge clk);
      check("R9 three words idle", {31'h0, busy}, 32'h0);
      put_word(32'h7000_0003);
      @(negedge clk);
      check("R9 started", {31'h0, busy}, 32'h1);
      repeat (30) @(negedge clk);
      check("R8 results held", {31'h0, out_ne}, 32'h1);

      // R6 clear ignored while enabled
      wr_ctl(1, 0, 3'b000, 2'b00, 1, 0, 0);
      check("R6 ignored when enabled", {31'h0, out_ne}, 32'h1);

      // R10 R11 DMA lines
      wr_ctl(1, 0, 3'b000, 2'b00, 0, 1, 0);
      check("R10 in req", {31'h0, dma_in_req}, 32'h1);
      check("R10 in burst", {31'h0, dma_in_burst}, 32'h1);
      wr_ctl(1, 0, 3'b000, 2'b00, 0, 1, 1);
      check("R10 out req", {31'h0, dma_out_req}, 32'h1);
      check("R10 out burst", {31'h0, dma_out_burst}, 32'h1);
      check("R11 in held low", {31'h0, dma_in_req}, 32'h0);
      man_pop = 1;
      while (man_pop) @(negedge clk);
      @(negedge clk);
      check("R10 out single", {31'h0, dma_out_burst}, 32'h0);
      check("R8 still waiting", {31'h0, out_ne}, 32'h1);

      // R6 clear with unit disabled
      wr_ctl(0, 0, 3'b000, 2'b00, 0, 0, 0);
      put_word(32'h5555_0001);
      wr_ctl(0, 0, 3'b000, 2'b00, 1, 0, 0);
      check("R6 out emptied", {31'h0, out_ne}, 32'h0);
      check("R10 no in req when disabled", {31'h0, dma_in_req}, 32'h0);
      mon_on = 1;
      wr_ctl(1, 0, 3'b000, 2'b00, 0, 0, 0);
      send_block(32'h0000_4000);
      drain(200);
      check("R6 in emptied", exp_q.size(), 0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule